// File: doc/BRIEF.md
# Volt-Second Balance Edge Trimmer

This block evens out current between the two legs of a full bridge, or between two interleaved phases. Once per switching cycle it receives one current sample for each leg, already blanked and valid. The block scales the difference between the two samples by a selectable gain and adds it into a signed integrator. The integrator builds up over many cycles and stops at a selectable limit instead of wrapping. The integrator value then becomes four signed edge offsets, in 5 ns steps. The four edges are the rising and falling edges of two chosen PWM channels. Each edge has its own enable bit and its own polarity bit.

The correction runs only when all of these hold:
- the global enable is high;
- soft start is not blocking the function;
- the larger of the two leg samples is above a light-load threshold.

These conditions are evaluated at each cycle strobe. While the function is off, the integrator keeps its value and every offset reads zero. Once the conditions return, the correction resumes from the held value.

Top module: `vsb_edge_trim`

## Requirements
- R1: After reset the integrator is zero, the function is inactive and all four offsets are zero.
- R2: The integrator changes only at a clock edge where `strobe_i` is high and the function is enabled. On such an edge it adds delta = (leg_a_i - leg_b_i) arithmetically shifted right, so a negative difference rounds toward minus infinity.
- R3: `gain_i` selects the right shift applied to the leg difference. Code 0 shifts by 3 bits, code 1 by 2, code 2 by 1 and code 3 by 0.
- R4: The integrator saturates at +L and -L and never wraps. L is 16 steps when `range_hi_i`=0 and 32 steps when `range_hi_i`=1. Every offset output is also clamped to the L currently selected.
- R5: The function is enabled at a strobe only if max(leg_a_i, leg_b_i) > `light_thresh_i` (strictly greater). Otherwise the integrator holds and all offsets read zero until a later strobe enables it.
- R6: A strobe with both `ss_active_i`=1 and `ss_block_i`=1 disables the function: the integrator holds and the offsets are zero. With `ss_block_i`=0, soft start has no effect.
- R7: A strobe with `bal_en_i`=0 disables the function: the integrator holds and the offsets are zero.
- R8: `edge_ofs_o` holds four 7-bit two's-complement fields. Field k is bits [7k+6:7k]. Index 0 is channel A rising, 1 is channel A falling, 2 is channel B rising and 3 is channel B falling. A field whose `edge_en_i[k]`=0 reads zero.
- R9: An enabled field carries the clamped integrator value when `edge_dir_i[k]`=0 and its negation when `edge_dir_i[k]`=1.
- R10: The enabled/disabled state is updated only at strobes. Between strobes, changes on the enable, soft-start and threshold inputs do not change the integrator or whether the offsets are forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One pulse per switching cycle; the leg samples are valid with it |
| leg_a_i | input | 10 | Blanked current sample, leg A (unsigned) |
| leg_b_i | input | 10 | Blanked current sample, leg B (unsigned) |
| light_thresh_i | input | 10 | Light-load threshold |
| bal_en_i | input | 1 | Global enable |
| ss_active_i | input | 1 | Soft start in progress |
| ss_block_i | input | 1 | Disable the function during soft start |
| gain_i | input | 2 | Loop gain code |
| range_hi_i | input | 1 | Offset limit: 0 = ±16 steps, 1 = ±32 steps |
| edge_en_i | input | 4 | Per-edge enable |
| edge_dir_i | input | 4 | Per-edge polarity, 1 = negate |
| edge_ofs_o | output | 28 | Four signed edge offsets, 7 bits each, in 5 ns steps |

## Verification
Every edge offset is a direct function of the integrator, so an integrator fault appears at the ports in the cycle after the strobe that produced it. A wrong shift or a wrong sign shows as an offset error equal to the mis-scaled difference. A missing clamp shows as a field beyond ±16 or ±32, or as a wrapped sign, within a few saturating strobes. A fault in the enable state or its hold behaviour shows as nonzero offsets after a disabling strobe, or as zero offsets after an enabling one. In either case the error is visible one clock after that strobe.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int unsigned NUM_EDGES = 4;

  typedef enum logic [1:0] {
    GAIN_DIV8 = 2'd0,
    GAIN_DIV4 = 2'd1,
    GAIN_DIV2 = 2'd2,
    GAIN_DIV1 = 2'd3
  } gain_e;

  typedef enum int unsigned {
    EDGE_A_RISE = 0,
    EDGE_A_FALL = 1,
    EDGE_B_RISE = 2,
    EDGE_B_FALL = 3
  } edge_idx_e;
endpackage

// File: rtl/vsb_gate.sv
module vsb_gate #(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic [SAMPLE_W-1:0] leg_a_i,
  input  logic [SAMPLE_W-1:0] leg_b_i,
  input  logic [SAMPLE_W-1:0] thresh_i,
  input  logic                bal_en_i,
  input  logic                ss_active_i,
  input  logic                ss_block_i,
  output logic                update_o,
  output logic                active_o
);
  logic above_thr;
  logic allowed;
  logic active_q;

  assign above_thr = (leg_a_i > thresh_i) || (leg_b_i > thresh_i);
  assign allowed   = bal_en_i && !(ss_active_i && ss_block_i) && above_thr;
  assign update_o  = strobe_i && allowed;

  // state only moves at a strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= 1'b0;
    else if (strobe_i) active_q <= allowed;
  end

  assign active_o = active_q;
endmodule

// File: rtl/vsb_integrator.sv
module vsb_integrator #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned LIM_LO   = 16,
  parameter int unsigned LIM_HI   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    update_i,
  input  logic [SAMPLE_W-1:0]     leg_a_i,
  input  logic [SAMPLE_W-1:0]     leg_b_i,
  input  vsb_pkg::gain_e          gain_i,
  input  logic                    range_hi_i,
  output logic signed [OFS_W-1:0] acc_o,
  output logic signed [OFS_W-1:0] clamped_o
);
  localparam int unsigned SUM_W = ((SAMPLE_W > OFS_W) ? SAMPLE_W : OFS_W) + 2;
  localparam logic signed [SUM_W-1:0] LIM_LO_S = SUM_W'(LIM_LO);
  localparam logic signed [SUM_W-1:0] LIM_HI_S = SUM_W'(LIM_HI);

  function automatic logic signed [SUM_W-1:0] clamp_f(
    input logic signed [SUM_W-1:0] v,
    input logic signed [SUM_W-1:0] lim
  );
    if (v > lim)       return lim;
    else if (v < -lim) return -lim;
    else               return v;
  endfunction

  logic signed [SAMPLE_W:0]   diff;
  logic signed [SAMPLE_W:0]   delta;
  logic [1:0]                 shamt;
  logic signed [SUM_W-1:0]    delta_x;
  logic signed [SUM_W-1:0]    acc_x;
  logic signed [SUM_W-1:0]    sum;
  logic signed [SUM_W-1:0]    lim;
  logic signed [SUM_W-1:0]    sat;
  logic signed [SUM_W-1:0]    out_x;
  logic signed [OFS_W-1:0]    acc_q;

  assign diff    = $signed({1'b0, leg_a_i}) - $signed({1'b0, leg_b_i});
  assign shamt   = 2'd3 - gain_i;
  assign delta   = diff >>> shamt;
  assign delta_x = {{(SUM_W-SAMPLE_W-1){delta[SAMPLE_W]}}, delta};
  assign acc_x   = {{(SUM_W-OFS_W){acc_q[OFS_W-1]}}, acc_q};
  assign sum     = delta_x + acc_x;
  assign lim     = range_hi_i ? LIM_HI_S : LIM_LO_S;
  assign sat     = clamp_f(sum, lim);
  assign out_x   = clamp_f(acc_x, lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (update_i) acc_q <= sat[OFS_W-1:0];
  end

  assign acc_o     = acc_q;
  assign clamped_o = out_x[OFS_W-1:0];
endmodule

// File: rtl/vsb_edge_map.sv
module vsb_edge_map #(
  parameter int unsigned OFS_W = 7
) (
  input  logic                                active_i,
  input  logic signed [OFS_W-1:0]             value_i,
  input  logic [vsb_pkg::NUM_EDGES-1:0]       edge_en_i,
  input  logic [vsb_pkg::NUM_EDGES-1:0]       edge_dir_i,
  output logic [vsb_pkg::NUM_EDGES*OFS_W-1:0] edge_ofs_o
);
  logic signed [OFS_W-1:0] neg_value;
  assign neg_value = -value_i;

  for (genvar k = 0; k < vsb_pkg::NUM_EDGES; k++) begin : g_edge
    always_comb begin
      if (!(active_i && edge_en_i[k])) edge_ofs_o[k*OFS_W +: OFS_W] = '0;
      else if (edge_dir_i[k])          edge_ofs_o[k*OFS_W +: OFS_W] = neg_value;
      else                             edge_ofs_o[k*OFS_W +: OFS_W] = value_i;
    end
  end
endmodule

// File: rtl/vsb_edge_trim.sv
module vsb_edge_trim #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned LIM_LO   = 16,
  parameter int unsigned LIM_HI   = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                strobe_i,
  input  logic [SAMPLE_W-1:0]                 leg_a_i,
  input  logic [SAMPLE_W-1:0]                 leg_b_i,
  input  logic [SAMPLE_W-1:0]                 light_thresh_i,
  input  logic                                bal_en_i,
  input  logic                                ss_active_i,
  input  logic                                ss_block_i,
  input  logic [1:0]                          gain_i,
  input  logic                                range_hi_i,
  input  logic [vsb_pkg::NUM_EDGES-1:0]       edge_en_i,
  input  logic [vsb_pkg::NUM_EDGES-1:0]       edge_dir_i,
  output logic [vsb_pkg::NUM_EDGES*OFS_W-1:0] edge_ofs_o
);
  logic                    update_w;
  logic                    active_w;
  logic signed [OFS_W-1:0] acc_w;
  logic signed [OFS_W-1:0] value_w;

  vsb_gate #(.SAMPLE_W(SAMPLE_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .leg_a_i     (leg_a_i),
    .leg_b_i     (leg_b_i),
    .thresh_i    (light_thresh_i),
    .bal_en_i    (bal_en_i),
    .ss_active_i (ss_active_i),
    .ss_block_i  (ss_block_i),
    .update_o    (update_w),
    .active_o    (active_w)
  );

  vsb_integrator #(
    .SAMPLE_W (SAMPLE_W),
    .OFS_W    (OFS_W),
    .LIM_LO   (LIM_LO),
    .LIM_HI   (LIM_HI)
  ) u_integ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .update_i   (update_w),
    .leg_a_i    (leg_a_i),
    .leg_b_i    (leg_b_i),
    .gain_i     (vsb_pkg::gain_e'(gain_i)),
    .range_hi_i (range_hi_i),
    .acc_o      (acc_w),
    .clamped_o  (value_w)
  );

  vsb_edge_map #(.OFS_W(OFS_W)) u_map (
    .active_i   (active_w),
    .value_i    (value_w),
    .edge_en_i  (edge_en_i),
    .edge_dir_i (edge_dir_i),
    .edge_ofs_o (edge_ofs_o)
  );
endmodule

// File: rtl/vsb_edge_trim_chk.sv
module vsb_edge_trim_chk #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned LIM_LO   = 16,
  parameter int unsigned LIM_HI   = 32
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                strobe_i,
  input logic [SAMPLE_W-1:0]                 leg_a_i,
  input logic [SAMPLE_W-1:0]                 leg_b_i,
  input logic [SAMPLE_W-1:0]                 light_thresh_i,
  input logic                                bal_en_i,
  input logic                                ss_active_i,
  input logic                                ss_block_i,
  input logic                                range_hi_i,
  input logic [vsb_pkg::NUM_EDGES-1:0]       edge_en_i,
  input logic [vsb_pkg::NUM_EDGES*OFS_W-1:0] edge_ofs_o,
  input logic signed [OFS_W-1:0]             acc_i
);
  localparam int N = vsb_pkg::NUM_EDGES;

  logic over_lo;
  logic light;

  always_comb begin
    over_lo = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (int'($signed(edge_ofs_o[k*OFS_W +: OFS_W])) > int'(LIM_LO) ||
          int'($signed(edge_ofs_o[k*OFS_W +: OFS_W])) < -int'(LIM_LO))
        over_lo = 1'b1;
    end
  end

  assign light = !((leg_a_i > light_thresh_i) || (leg_b_i > light_thresh_i));

  p_acc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> acc_i == $past(acc_i));

  p_acc_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(acc_i) <= int'(LIM_HI) && int'(acc_i) >= -int'(LIM_HI));

  p_range_lo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !range_hi_i |-> !over_lo);

  p_light_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && light |=> acc_i == $past(acc_i) && edge_ofs_o == '0);

  p_ss_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && ss_active_i && ss_block_i |=> edge_ofs_o == '0);

  p_off_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !bal_en_i |=> edge_ofs_o == '0 && acc_i == $past(acc_i));

  for (genvar k = 0; k < N; k++) begin : g_mask
    p_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_en_i[k] |-> edge_ofs_o[k*OFS_W +: OFS_W] == '0);
  end
endmodule

bind vsb_edge_trim vsb_edge_trim_chk #(
  .SAMPLE_W (SAMPLE_W),
  .OFS_W    (OFS_W),
  .LIM_LO   (LIM_LO),
  .LIM_HI   (LIM_HI)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .strobe_i       (strobe_i),
  .leg_a_i        (leg_a_i),
  .leg_b_i        (leg_b_i),
  .light_thresh_i (light_thresh_i),
  .bal_en_i       (bal_en_i),
  .ss_active_i    (ss_active_i),
  .ss_block_i     (ss_block_i),
  .range_hi_i     (range_hi_i),
  .edge_en_i      (edge_en_i),
  .edge_ofs_o     (edge_ofs_o),
  .acc_i          (acc_w)
);

// File: tb/vsb_edge_trim_test.sv
module vsb_edge_trim_test;
  localparam int SW = 10;
  localparam int OW = 7;
  localparam int N  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe = 1'b0;
  logic [SW-1:0] leg_a = '0, leg_b = '0, thr = '0;
  logic          en = 1'b0, ss = 1'b0, ss_blk = 1'b0;
  logic [1:0]    gain = 2'd0;
  logic          rng = 1'b0;
  logic [N-1:0]  e_en = '0, e_dir = '0;
  logic [N*OW-1:0] ofs;

  int    errors = 0, checks = 0;
  int    acc_m = 0;
  bit    act_m = 1'b0;
  string cause_m = "R1";
  string tag_ovr = "";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  vsb_edge_trim uut (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .leg_a_i(leg_a), .leg_b_i(leg_b),
    .light_thresh_i(thr), .bal_en_i(en), .ss_active_i(ss), .ss_block_i(ss_blk),
    .gain_i(gain), .range_hi_i(rng), .edge_en_i(e_en), .edge_dir_i(e_dir),
    .edge_ofs_o(ofs)
  );

  function automatic int clamp(int v, int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic int lim_of(bit r);
    return r ? 32 : 16;
  endfunction

  // reference update at a clock edge
  task automatic model_edge();
    bit cond;
    int d;
    if (!strobe) return;
    cond = en && !(ss && ss_blk) && ((leg_a > thr) || (leg_b > thr));
    act_m = cond;
    if (!en) cause_m = "R7";
    else if (ss && ss_blk) cause_m = "R6";
    else if (!cond) cause_m = "R5";
    if (cond) begin
      d = (int'(leg_a) - int'(leg_b)) >>> (3 - int'(gain));
      acc_m = clamp(acc_m + d, lim_of(rng));
    end
  endtask

  task automatic check_outs();
    int lim, v, exp_v, got;
    string tag;
    lim = lim_of(rng);
    v = clamp(acc_m, lim);
    for (int k = 0; k < N; k++) begin
      got = int'($signed(ofs[k*OW +: OW]));
      if (!act_m) begin exp_v = 0; tag = cause_m; end
      else if (!e_en[k]) begin exp_v = 0; tag = "R8"; end
      else begin
        exp_v = e_dir[k] ? -v : v;
        tag = e_dir[k] ? "R9" : ((v == lim || v == -lim) ? "R4" : "R2");
      end
      if (tag_ovr != "") tag = tag_ovr;
      checks++;
      if (got !== exp_v) begin
        errors++;
        $display("FAIL %s edge%0d: got %0d expected %0d", tag, k, got, exp_v);
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    acc_m = 0; act_m = 1'b0; cause_m = "R1";
    rst_n = 1'b1;
  endtask

  task automatic strobe_cyc(int a, int b);
    leg_a = SW'(a); leg_b = SW'(b); strobe = 1'b1;
    cycle();
    strobe = 1'b0;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(1234));
    e_en = 4'hF;
    do_reset();
    tag_ovr = "R1";
    check_outs();
    cycle();
    tag_ovr = "";

    // R3 gain sweep from zero: diff 80
    en = 1'b1; thr = 10'd0; rng = 1'b1; e_dir = 4'b0000;
    for (int g = 0; g < 4; g++) begin
      do_reset();
      gain = 2'(g);
      tag_ovr = "R3";
      strobe_cyc(100, 20);
      cycle();
    end
    // R2 negative difference floors toward minus infinity
    do_reset(); gain = 2'd0; tag_ovr = "R2";
    strobe_cyc(0, 3);
    strobe_cyc(5, 0);

    // R4 saturation high and low, range switch
    do_reset(); gain = 2'd3; rng = 1'b0; tag_ovr = "R4";
    for (int i = 0; i < 3; i++) strobe_cyc(500, 0);
    rng = 1'b1; cycle();
    for (int i = 0; i < 3; i++) strobe_cyc(500, 0);
    rng = 1'b0; cycle();
    for (int i = 0; i < 4; i++) strobe_cyc(0, 900);
    rng = 1'b1; cycle();

    // R9 polarity mix, R8 masking
    tag_ovr = ""; e_dir = 4'b1010; cycle();
    e_en = 4'b0110; cycle();
    e_en = 4'hF;

    // R5 threshold boundary: equal is off, one above is on
    do_reset(); gain = 2'd3; rng = 1'b1; thr = 10'd50;
    tag_ovr = "R5";
    strobe_cyc(50, 40);
    strobe_cyc(51, 40);
    strobe_cyc(50, 50);

    // R6 soft start with and without block
    tag_ovr = "R6"; thr = 10'd0;
    ss = 1'b1; ss_blk = 1'b1; strobe_cyc(30, 20);
    ss_blk = 1'b0; strobe_cyc(30, 20);
    ss = 1'b0;

    // R7 global disable, R10 no change between strobes
    tag_ovr = "R7"; en = 1'b0; strobe_cyc(30, 20);
    tag_ovr = "R10"; en = 1'b1; cycle(); cycle();
    strobe_cyc(22, 20);
    en = 1'b0; thr = 10'd1000; ss = 1'b1; ss_blk = 1'b1; cycle(); cycle();
    en = 1'b1; thr = 10'd0; ss = 1'b0; ss_blk = 1'b0;
    tag_ovr = "";

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      strobe = ($urandom_range(0, 1) == 1);
      leg_a  = SW'($urandom_range(0, 1023));
      leg_b  = ($urandom_range(0, 3) == 0) ? SW'($urandom_range(0, 1023))
                                           : SW'(int'(leg_a) ^ $urandom_range(0, 63));
      thr    = ($urandom_range(0, 7) == 0) ? SW'($urandom_range(0, 1023))
                                           : SW'($urandom_range(0, 40));
      en     = ($urandom_range(0, 15) != 0);
      ss     = ($urandom_range(0, 7) == 0);
      ss_blk = $urandom_range(0, 1);
      gain   = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 31) == 0) rng = ~rng;
      e_en   = 4'($urandom_range(0, 15));
      e_dir  = 4'($urandom_range(0, 15));
      cycle();
    end
    strobe = 1'b0;
    finish_run();
  end
endmodule